// File: doc/BRIEF.md
# Third-Order Fractional-N Divide Sequencer

This block sets the feedback division of a fractional-N synthesizer loop. It runs on the divided-down oscillator clock. A built-in down-counter divides that clock by a per-cycle value and emits one feedback strobe per count; that strobe is the edge handed to the phase/frequency detector. At every strobe a cascade of three modulus-M accumulators advances once. Their carries are combined into a signed offset that is added to the integer setting. Over time the mean division therefore becomes INT + FRAC/MOD, and the quantization error is pushed toward high offsets from the carrier.

The modulus can be any integer from 2 to 4095, so each accumulator wraps by subtraction rather than by bit overflow. A three-bit noise/spur mode field switches a pseudo-random dither on or off. The dither drives one extra least-significant bit into the last accumulator. A counter-reset input and a power-down input each force the whole datapath back to its load state. When both are released, the next feedback strobe comes at once, so the divided edge restarts aligned with the reference side.

Top module: `fracn_div_ctrl`

## Requirements
- R1: While `rst_n` is low, or `cnt_reset` or `pwr_down` is high, `div_value` reads 0 and `fb_edge` is low. The accumulator, carry-history and dither state all return to their start values.
- R2: In the first clock cycle where reset and both hold inputs are inactive, `fb_edge` is high.
- R3: After an `fb_edge` cycle, `div_value` takes a new value N in the next cycle and holds it, and the next `fb_edge` comes exactly N cycles after the previous one.
- R4: `int_val`, `frac_val`, `mod_val` and `ns_mode` are used only in `fb_edge` cycles. Changes that are undone before the next `fb_edge` alter neither `div_value` nor the strobe spacing.
- R5: Each accumulator stage adds its input (plus its increment bit) to its state. When the sum reaches MOD, the stage sets its carry and keeps sum − MOD. Stage 1 adds FRAC, stage 2 adds stage 1's new state, stage 3 adds stage 2's new state. The new value is INT + c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where ' means the carry of the previous step. The offset is always between −3 and +4.
- R6: With dither off, FRAC = 0 gives a constant division of INT. FRAC ≥ MOD is treated as FRAC = MOD, which gives a constant INT + 1.
- R7: Dither is on only when `ns_mode` = 3'b000. It then adds a pseudo-random bit, which is nonzero often enough to be seen, into stage 3 at each step. With FRAC = 0 and MOD = 2 the division then departs from INT. Every other mode code (for example 3'b001, 3'b111, 3'b010) gives no dither.
- R8: Starting from the load state, the sum of (div_value − INT) over the first K values stays within [⌊K·FRAC/MOD⌋ − 1, ⌊K·FRAC/MOD⌋ + 2], with or without dither.
- R9: When the MOD sampled at a step differs from the one sampled at the previous step, that step starts from zeroed accumulators and carry history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided oscillator clock that the counter divides |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_val | input | 8 | Integer part of the division (31 to 255) |
| frac_val | input | 12 | Fractional numerator |
| mod_val | input | 12 | Fractional modulus (2 to 4095) |
| ns_mode | input | 3 | Noise/spur mode; 3'b000 turns dither on |
| cnt_reset | input | 1 | Holds all counters in their load state |
| pwr_down | input | 1 | Power-down; forces the load state |
| div_value | output | 9 | Division applied to the count in progress |
| fb_edge | output | 1 | One-cycle feedback strobe at the end of each count |

## Verification
A wrong accumulator or carry-history value does not hide. It shows as a wrong `div_value` on the cycle after the very next strobe, at most about 260 clocks later, so the bench compares every division value with an independent model for deterministic settings. A counter fault shows as wrong spacing between strobes, which is checked on every count. Dither faults show only statistically, so they are caught by the mode-gated visibility test and by the bounded running sum over a long run.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int MASH_ORDER = 3;
  localparam int OFF_W      = 4;
  localparam int NS_W       = 3;
  localparam logic [NS_W-1:0] NS_DITHER_ON = 3'b000;

  typedef logic signed [OFF_W-1:0] mash_off_t;
endpackage

// File: rtl/fracn_acc_stage.sv
module fracn_acc_stage #(
  parameter int W = 12
) (
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] addend,
  input  logic [W-1:0] modulus,
  input  logic         inc,
  output logic [W-1:0] acc_next,
  output logic         carry
);
  logic [W:0] sum_ext;
  logic [W:0] wrapped;

  always_comb begin
    sum_ext  = {1'b0, acc_in} + {1'b0, addend} + {{W{1'b0}}, inc};
    wrapped  = sum_ext - {1'b0, modulus};
    carry    = (sum_ext >= {1'b0, modulus});
    acc_next = carry ? wrapped[W-1:0] : sum_ext[W-1:0];
  end
endmodule

// File: rtl/fracn_noise_comb.sv
module fracn_noise_comb
  import fracn_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  step,
  input  logic                  restart,
  input  logic [MASH_ORDER-1:0] carry,
  output mash_off_t             offset
);
  logic c2_q, c3_q, c3_qq;
  logic c2_d, c3_d, c3_dd;
  logic c2_p, c3_p, c3_pp;

  always_comb begin
    c2_p = restart ? 1'b0 : c2_q;
    c3_p = restart ? 1'b0 : c3_q;
    c3_pp = restart ? 1'b0 : c3_qq;
    offset = mash_off_t'({3'b000, carry[0]})
           + mash_off_t'({3'b000, carry[1]})
           - mash_off_t'({3'b000, c2_p})
           + mash_off_t'({3'b000, carry[2]})
           - mash_off_t'({2'b00, c3_p, 1'b0})
           + mash_off_t'({3'b000, c3_pp});
  end

  always_comb begin
    c2_d  = c2_q;
    c3_d  = c3_q;
    c3_dd = c3_qq;
    if (clear) begin
      c2_d  = 1'b0;
      c3_d  = 1'b0;
      c3_dd = 1'b0;
    end else if (step) begin
      c2_d  = carry[1];
      c3_d  = carry[2];
      c3_dd = c3_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_q  <= 1'b0;
      c3_q  <= 1'b0;
      c3_qq <= 1'b0;
    end else begin
      c2_q  <= c2_d;
      c3_q  <= c3_d;
      c3_qq <= c3_dd;
    end
  end

  // R5: the combined offset never leaves the -3..+4 window
  assert_offset_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (offset >= -4'sd3 && offset <= 4'sd4));
endmodule

// File: rtl/fracn_dither_lfsr.sv
module fracn_dither_lfsr #(
  parameter int          W     = 15,
  parameter int          TAP_A = 14,
  parameter int          TAP_B = 13,
  parameter int unsigned SEED  = 'h4A73
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic enable,
  output logic dith_bit
);
  localparam logic [W-1:0] SEED_V = W'(SEED);

  logic [W-1:0] lfsr_q;
  logic [W-1:0] lfsr_d;
  logic         fb_bit;

  always_comb begin
    fb_bit   = lfsr_q[TAP_A] ^ lfsr_q[TAP_B];
    dith_bit = enable & lfsr_q[0];
    lfsr_d   = lfsr_q;
    if (clear)      lfsr_d = SEED_V;
    else if (step)  lfsr_d = {lfsr_q[W-2:0], fb_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED_V;
    else        lfsr_q <= lfsr_d;
  end

  // R7: the sequence generator must never lock up in the all-zero state
  assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/fracn_fb_counter.sv
module fracn_fb_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] load_val,
  output logic         tc
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    tc = (cnt_q == '0) && !hold;
    if (hold)    cnt_d = '0;
    else if (tc) cnt_d = load_val - W'(1);
    else         cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
  import fracn_pkg::*;
#(
  parameter int          INT_W     = 8,
  parameter int          MOD_W     = 12,
  parameter int          LFSR_W    = 15,
  parameter int          LFSR_TAPA = 14,
  parameter int          LFSR_TAPB = 13,
  parameter int unsigned LFSR_SEED = 'h4A73
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [INT_W-1:0]     int_val,
  input  logic [MOD_W-1:0]     frac_val,
  input  logic [MOD_W-1:0]     mod_val,
  input  logic [NS_W-1:0]      ns_mode,
  input  logic                 cnt_reset,
  input  logic                 pwr_down,
  output logic [INT_W:0]       div_value,
  output logic                 fb_edge
);
  localparam int DIV_W  = INT_W + 1;
  localparam int STAGES = MASH_ORDER;

  logic             run_q;
  logic             hold_i;
  logic             boundary;
  logic             restart;
  logic             dith_bit;
  logic [MOD_W-1:0] frac_eff;
  logic [MOD_W-1:0] mod_q, mod_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] new_n;
  mash_off_t        offset;

  logic [MOD_W-1:0]  acc_q   [STAGES];
  logic [MOD_W-1:0]  acc_d   [STAGES];
  logic [MOD_W-1:0]  acc_in  [STAGES];
  logic [MOD_W-1:0]  acc_nxt [STAGES];
  logic [MOD_W-1:0]  addend  [STAGES];
  logic [STAGES-1:0] inc;
  logic [STAGES-1:0] carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  assign hold_i   = cnt_reset | pwr_down | ~run_q;
  assign boundary = fb_edge;
  assign restart  = (mod_val != mod_q);
  assign frac_eff = (frac_val > mod_val) ? mod_val : frac_val;

  fracn_dither_lfsr #(
    .W(LFSR_W), .TAP_A(LFSR_TAPA), .TAP_B(LFSR_TAPB), .SEED(LFSR_SEED)
  ) u_dither (
    .clk(clk), .rst_n(rst_n), .clear(hold_i), .step(boundary),
    .enable(ns_mode == NS_DITHER_ON), .dith_bit(dith_bit)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign addend[k] = frac_eff;
      assign inc[k]    = 1'b0;
    end else if (k == STAGES - 1) begin : g_tail
      assign addend[k] = acc_nxt[k-1];
      assign inc[k]    = dith_bit;
    end else begin : g_mid
      assign addend[k] = acc_nxt[k-1];
      assign inc[k]    = 1'b0;
    end

    assign acc_in[k] = restart ? '0 : acc_q[k];

    fracn_acc_stage #(.W(MOD_W)) u_acc (
      .acc_in(acc_in[k]), .addend(addend[k]), .modulus(mod_val),
      .inc(inc[k]), .acc_next(acc_nxt[k]), .carry(carry[k])
    );

    always_comb begin
      acc_d[k] = acc_q[k];
      if (hold_i)        acc_d[k] = '0;
      else if (boundary) acc_d[k] = acc_nxt[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q[k] <= '0;
      else        acc_q[k] <= acc_d[k];
    end

    // R5: every stage keeps its residue below the modulus it wrapped against
    assert_acc_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && mod_val >= MOD_W'(2)) |=> (acc_q[k] < mod_q));
  end

  fracn_noise_comb u_comb (
    .clk(clk), .rst_n(rst_n), .clear(hold_i), .step(boundary),
    .restart(restart), .carry(carry), .offset(offset)
  );

  assign new_n = {1'b0, int_val} + {{(DIV_W-OFF_W){offset[OFF_W-1]}}, offset};

  always_comb begin
    div_d = div_q;
    mod_d = mod_q;
    if (hold_i) begin
      div_d = '0;
      mod_d = '0;
    end else if (boundary) begin
      div_d = new_n;
      mod_d = mod_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      mod_q <= '0;
    end else begin
      div_q <= div_d;
      mod_q <= mod_d;
    end
  end

  fracn_fb_counter #(.W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hold(hold_i), .load_val(new_n), .tc(fb_edge)
  );

  assign div_value = div_q;

  // R1: a hold clears the presented division value
  assert_hold_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (div_value == '0));

  // R2: leaving the hold produces an immediate feedback strobe
  assert_release_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_i) |-> fb_edge);

  // R4: between strobes the division value does not move
  assert_mid_count_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fb_edge && !hold_i) |=> $stable(div_value));

  // R5: each new division lies within INT-3 .. INT+4 of the sampled integer
  assert_div_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fb_edge |=> ((div_value + DIV_W'(3) >= {1'b0, $past(int_val)}) &&
                 (div_value <= {1'b0, $past(int_val)} + DIV_W'(4))));
endmodule

// File: tb/fracn_div_ctrl_tb.sv
module fracn_div_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic [7:0] int_val;
  logic [11:0] frac_val;
  logic [11:0] mod_val;
  logic [2:0] ns_mode;
  logic       cnt_reset;
  logic       pwr_down;
  logic [8:0] div_value;
  logic       fb_edge;

  fracn_div_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .int_val(int_val), .frac_val(frac_val),
    .mod_val(mod_val), .ns_mode(ns_mode), .cnt_reset(cnt_reset),
    .pwr_down(pwr_down), .div_value(div_value), .fb_edge(fb_edge)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  string cur_req = "R5";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // reference model state
  int e1, e2, e3, h2, h3, hh3, m_prev;
  int sb_q[$];

  task automatic model_reset();
    e1 = 0; e2 = 0; e3 = 0; h2 = 0; h3 = 0; hh3 = 0; m_prev = 0;
  endtask

  task automatic model_step(input int iv, input int fv, input int mv, output int n);
    int x, s, c1, c2, c3;
    if (mv != m_prev) begin
      e1 = 0; e2 = 0; e3 = 0; h2 = 0; h3 = 0; hh3 = 0;
    end
    m_prev = mv;
    x  = (fv > mv) ? mv : fv;
    s  = e1 + x; c1 = s / mv; e1 = s % mv;
    s  = e2 + e1; c2 = s / mv; e2 = s % mv;
    s  = e3 + e2; c3 = s / mv; e3 = s % mv;
    n  = iv + c1 + (c2 - h2) + (c3 - 2 * h3 + hh3);
    hh3 = h3; h3 = c3; h2 = c2;
  endtask

  task automatic push_expected(input int k);
    int n;
    for (int i = 0; i < k; i++) begin
      model_step(int_val, frac_val, mod_val, n);
      sb_q.push_back(n);
    end
  endtask

  // monitor
  int  bcount = 0;
  int  sum_off = 0;
  int  n_vary = 0;
  int  gap = 0;
  int  last_n = 0;
  bit  have_n = 1'b0;
  bit  prev_fb = 1'b0;

  always @(negedge clk) begin
    if (!rst_n || cnt_reset || pwr_down) begin
      gap = 0; have_n = 1'b0; prev_fb = 1'b0;
    end else begin
      gap++;
      if (prev_fb) begin
        int expv;
        bcount++;
        sum_off += int'(div_value) - int'(int_val);
        if (int'(div_value) != int'(int_val)) n_vary++;
        if (sb_q.size() > 0) begin
          expv = sb_q.pop_front();
          chk(int'(div_value) == expv, cur_req, int'(div_value), expv);
        end
        last_n = int'(div_value);
        have_n = 1'b1;
      end
      if (fb_edge) begin
        if (have_n) chk(gap == last_n, "R3 strobe spacing", gap, last_n);
        gap = 0;
      end
      prev_fb = fb_edge;
    end
  end

  task automatic wait_sb_empty();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic wait_bounds(input int k);
    int target;
    target = bcount + k;
    while (bcount < target) @(negedge clk);
  endtask

  task automatic restart_run(input int iv, input int fv, input int mv, input int md,
                             input int k, input bit use_pd, input string tag);
    @(posedge clk); #1;
    if (use_pd) pwr_down = 1'b1; else cnt_reset = 1'b1;
    int_val = 8'(iv); frac_val = 12'(fv); mod_val = 12'(mv); ns_mode = 3'(md);
    @(negedge clk); @(negedge clk);
    chk(div_value == 9'd0, "R1 hold value", int'(div_value), 0);
    chk(fb_edge == 1'b0, "R1 hold strobe", int'(fb_edge), 0);
    model_reset();
    sum_off = 0; n_vary = 0;
    cur_req = tag;
    push_expected(k);
    @(posedge clk); #1;
    cnt_reset = 1'b0; pwr_down = 1'b0;
    @(negedge clk);
    chk(fb_edge == 1'b1, "R2 release strobe", int'(fb_edge), 1);
    wait_sb_empty();
  endtask

  task automatic change_run(input int iv, input int fv, input int mv, input int md,
                            input int k, input string tag);
    @(posedge clk); #1;
    int_val = 8'(iv); frac_val = 12'(fv); mod_val = 12'(mv); ns_mode = 3'(md);
    cur_req = tag;
    push_expected(k);
    wait_sb_empty();
  endtask

  initial begin
    rst_n = 1'b0; cnt_reset = 1'b1; pwr_down = 1'b0;
    int_val = 8'd40; frac_val = 12'd0; mod_val = 12'd100; ns_mode = 3'b001;
    repeat (3) @(negedge clk);
    chk(div_value == 9'd0, "R1 reset value", int'(div_value), 0);
    chk(fb_edge == 1'b0, "R1 reset strobe", int'(fb_edge), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R6: zero fraction keeps the minimum integer
    restart_run(31, 0, 100, 3'b001, 12, 1'b0, "R6 zero fraction");
    // R6: fraction equal to and above modulus both give INT+1
    restart_run(255, 50, 50, 3'b111, 8, 1'b0, "R6 frac equals mod");
    change_run(255, 60, 50, 3'b111, 8, "R6 frac above mod");
    // R5: exact sequences for several fraction patterns
    restart_run(100, 3, 7, 3'b001, 40, 1'b0, "R5 3/7 sequence");
    restart_run(64, 1, 4095, 3'b010, 20, 1'b0, "R5 1/4095 sequence");
    restart_run(64, 4094, 4095, 3'b001, 20, 1'b0, "R5 4094/4095 sequence");
    restart_run(200, 1, 2, 3'b111, 24, 1'b0, "R5 1/2 sequence");

    // R4: inputs toggled mid-count and restored are ignored
    restart_run(40, 2, 5, 3'b001, 4, 1'b0, "R4 pre-glitch");
    cur_req = "R4 mid-count glitch";
    push_expected(6);
    @(posedge clk); #1;
    int_val = 8'd100; frac_val = 12'd4; mod_val = 12'd9; ns_mode = 3'b000;
    repeat (5) @(posedge clk);
    #1;
    int_val = 8'd40; frac_val = 12'd2; mod_val = 12'd5; ns_mode = 3'b001;
    wait_sb_empty();

    // R9: modulus change restarts the accumulators
    restart_run(50, 3, 7, 3'b001, 10, 1'b0, "R9 before modulus change");
    change_run(50, 5, 11, 3'b001, 14, "R9 after modulus change");
    change_run(50, 5, 11, 3'b001, 6, "R9 same modulus continues");

    // R1/R2 via power-down
    restart_run(77, 9, 13, 3'b001, 10, 1'b1, "R1 power-down restart");

    // R7: dither visible only in mode 000
    restart_run(45, 0, 2, 3'b000, 0, 1'b0, "R7");
    wait_bounds(40);
    chk(n_vary > 0, "R7 dither visible in mode 000", n_vary, 1);
    restart_run(45, 0, 2, 3'b001, 0, 1'b0, "R7");
    wait_bounds(40);
    chk(n_vary == 0, "R7 no dither in mode 001", n_vary, 0);
    restart_run(45, 0, 2, 3'b111, 0, 1'b0, "R7");
    wait_bounds(40);
    chk(n_vary == 0, "R7 no dither in mode 111", n_vary, 0);
    restart_run(45, 0, 2, 3'b010, 0, 1'b0, "R7");
    wait_bounds(40);
    chk(n_vary == 0, "R7 no dither in mode 010", n_vary, 0);

    // R8: bounded running sum with dither on (200*5/13 -> 76)
    restart_run(40, 5, 13, 3'b000, 0, 1'b0, "R8");
    wait_bounds(200);
    chk(sum_off >= 75 && sum_off <= 78, "R8 dithered running sum", sum_off, 76);
    // R8: same bound without dither (200*1000/4001 -> 49)
    restart_run(60, 1000, 4001, 3'b001, 0, 1'b0, "R8");
    wait_bounds(200);
    chk(sum_off >= 48 && sum_off <= 51, "R8 plain running sum", sum_off, 49);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule